// File: doc/BRIEF.md
# Decode Operand Bypass Selector

This block sits in the decode stage of a five-stage in-order pipeline. It produces the two operand values, A and B, that decode hands to execute. Each operand names a source register. The block compares that ID with the destinations of the instructions further down the pipe. When one or more of them will write that register, it takes the newest pending value. Otherwise it passes through the value read from the register file. The logic is purely combinational and settles within the decode cycle.

Five producers can bypass into decode:
- the ALU result being computed in execute in the current cycle;
- the load data being read in the memory stage;
- the ALU result latched in the memory register;
- the load data latched in the write-back register;
- the ALU result latched in the write-back register.

When several producers match, the youngest one wins. This keeps the result the same as sequential execution. Register ID 15 is the "no register" code and never matches.

Operand A has a further source. Instructions that carry their incremented PC forward, such as call and conditional jump, take that PC as operand A, whatever the bypass paths hold.

The block has no state, so the house state-machine layout reduces to fixed selection "states", one per source:
- EXE_ALU
- MEM_LOAD
- MEM_ALU
- WB_LOAD
- WB_ALU
- register file fallback

A "transition" is the priority step from one source to the next lower one when a source does not match.

Top module: `fwd_operand_select`

## Requirements
- R1: When no bypass destination equals an operand's source ID, that operand equals its register-file read value.
- R2: When the execute destination matches the source ID and the move is not cancelled, the operand equals the execute ALU result, whatever the other paths hold.
- R3: Among the other matching paths, priority runs in this order: memory load value, memory ALU result, write-back load value, write-back ALU result.
- R4: ID 15 never matches. A source of 15 always yields the register-file value, even when a destination is also 15. A destination of 15 never supplies a value.
- R5: While `use_pc` is high, operand A equals `pc_next`, whatever bypass matches exist, and operand B is unaffected.
- R6: While `e_cancel` is high, the execute path behaves as if its destination were 15. The selection then falls to the next matching path.
- R7: Operand B is selected from `src_b` alone, by the same rules. Changing `src_a` has no effect on operand B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 4 | Source register ID of operand A |
| src_b | input | 4 | Source register ID of operand B |
| rf_a | input | W | Register-file read value for A |
| rf_b | input | W | Register-file read value for B |
| use_pc | input | 1 | Operand A takes the incremented PC |
| pc_next | input | W | Incremented PC of the decode instruction |
| e_dst | input | 4 | Execute-stage ALU destination |
| e_cancel | input | 1 | Failed conditional move: suppress the execute path |
| e_alu | input | W | ALU result computed in execute this cycle |
| m_dst_ld | input | 4 | Memory-stage load destination |
| m_ld | input | W | Load data read in the memory stage |
| m_dst_alu | input | 4 | Memory-stage ALU destination |
| m_alu | input | W | ALU result held in the memory register |
| w_dst_ld | input | 4 | Write-back load destination |
| w_ld | input | W | Load data held in the write-back register |
| w_dst_alu | input | 4 | Write-back ALU destination |
| w_alu | input | W | ALU result held in the write-back register |
| op_a | output | W | Selected operand A |
| op_b | output | W | Selected operand B |

## Verification
The hardest case to reach is several producers aiming at the same register at once, with the winner set by priority alone. In random stimulus the destination IDs rarely line up with the source ID. The bench therefore draws every ID from a narrow window of registers 13 to 15. This makes five-way collisions, ID-15 collisions and cancelled-execute collisions common. Every path also carries a distinct value, so a wrong winner always shows at the output. A reference model in the bench, written as a plain if-chain, gives the expected operands every cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int RID_W = 4;
    localparam logic [RID_W-1:0] RID_NONE = 4'hF;

    // Bypass paths, index order is priority order (0 = youngest producer)
    typedef enum logic [2:0] {
        SRC_EXE_ALU  = 3'd0,
        SRC_MEM_LOAD = 3'd1,
        SRC_MEM_ALU  = 3'd2,
        SRC_WB_LOAD  = 3'd3,
        SRC_WB_ALU   = 3'd4
    } fwd_src_e;

    localparam int NPATH = 5;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int NP = NPATH
) (
    input  logic [RID_W-1:0]         src,
    input  logic [NP-1:0][RID_W-1:0] dst,
    output logic [NP-1:0]            hit
);
    genvar i;
    generate
        for (i = 0; i < NP; i++) begin : g_cmp
            assign hit[i] = (src != RID_NONE) && (dst[i] == src);
        end
    endgenerate
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick #(
    parameter int NP = 5,
    parameter int W  = 64
) (
    input  logic [NP-1:0]        hit,
    input  logic [NP-1:0][W-1:0] vals,
    input  logic [W-1:0]         fallback,
    output logic [W-1:0]         value,
    output logic [NP-1:0]        grant
);
    logic found;

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (hit[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        value = fallback;
        for (int i = 0; i < NP; i++) begin
            if (grant[i]) value = vals[i];
        end
    end

    // R3: exactly one winner whenever any path matches, and only a matching one
    always_comb begin
        assert_one_winner_R3: assert ($onehot0(grant) && ((grant & ~hit) == '0)
                                      && ((hit != '0) == (grant != '0)))
            else $error("grant 0x%0h inconsistent with hit 0x%0h", grant, hit);
    end
endmodule

// File: rtl/fwd_operand_select.sv
module fwd_operand_select
    import fwd_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [3:0]   src_a,
    input  logic [3:0]   src_b,
    input  logic [W-1:0] rf_a,
    input  logic [W-1:0] rf_b,
    input  logic         use_pc,
    input  logic [W-1:0] pc_next,
    input  logic [3:0]   e_dst,
    input  logic         e_cancel,
    input  logic [W-1:0] e_alu,
    input  logic [3:0]   m_dst_ld,
    input  logic [W-1:0] m_ld,
    input  logic [3:0]   m_dst_alu,
    input  logic [W-1:0] m_alu,
    input  logic [3:0]   w_dst_ld,
    input  logic [W-1:0] w_ld,
    input  logic [3:0]   w_dst_alu,
    input  logic [W-1:0] w_alu,
    output logic [W-1:0] op_a,
    output logic [W-1:0] op_b
);
    localparam int NOPS = 2;

    logic [NPATH-1:0][RID_W-1:0] dsts;
    logic [NPATH-1:0][W-1:0]     vals;
    logic [NOPS-1:0][RID_W-1:0]  srcs;
    logic [NOPS-1:0][W-1:0]      rfv;
    logic [NOPS-1:0][W-1:0]      picked;
    logic [NOPS-1:0][NPATH-1:0]  hits;
    logic [NOPS-1:0][NPATH-1:0]  grants;

    // R6: a cancelled move looks like a write to the "no register" ID
    always_comb begin
        dsts[SRC_EXE_ALU]  = e_cancel ? RID_NONE : e_dst;
        dsts[SRC_MEM_LOAD] = m_dst_ld;
        dsts[SRC_MEM_ALU]  = m_dst_alu;
        dsts[SRC_WB_LOAD]  = w_dst_ld;
        dsts[SRC_WB_ALU]   = w_dst_alu;
        vals[SRC_EXE_ALU]  = e_alu;
        vals[SRC_MEM_LOAD] = m_ld;
        vals[SRC_MEM_ALU]  = m_alu;
        vals[SRC_WB_LOAD]  = w_ld;
        vals[SRC_WB_ALU]   = w_alu;
    end

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;
    assign rfv[0]  = rf_a;
    assign rfv[1]  = rf_b;

    genvar k;
    generate
        for (k = 0; k < NOPS; k++) begin : g_op
            fwd_match #(.NP(NPATH)) u_match (
                .src (srcs[k]),
                .dst (dsts),
                .hit (hits[k])
            );
            fwd_pick #(.NP(NPATH), .W(W)) u_pick (
                .hit      (hits[k]),
                .vals     (vals),
                .fallback (rfv[k]),
                .value    (picked[k]),
                .grant    (grants[k])
            );
        end
    endgenerate

    // R5: incremented PC overrides every bypass for operand A
    assign op_a = use_pc ? pc_next : picked[0];
    assign op_b = picked[1];

    always_comb begin
        assert_none_id_R4: assert (src_b != RID_NONE || op_b == rf_b)
            else $error("src 15 did not take register file value");
        assert_cancel_blocks_R6: assert (!e_cancel || !grants[1][SRC_EXE_ALU])
            else $error("cancelled execute path selected");
        assert_exe_first_R2: assert (!(grants[1] != '0 && hits[1][SRC_EXE_ALU]
                                       && !e_cancel) || grants[1][SRC_EXE_ALU])
            else $error("execute match lost priority");
        assert_rf_default_R1: assert (hits[1] != '0 || op_b == rf_b)
            else $error("no match but operand B not register file");
    end
endmodule

// File: tb/fwd_operand_select_tb.sv
module fwd_operand_select_tb;
    localparam int W = 64;
    localparam time PERIOD = 10;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [3:0]   src_a, src_b, e_dst, m_dst_ld, m_dst_alu, w_dst_ld, w_dst_alu;
    logic [W-1:0] rf_a, rf_b, pc_next, e_alu, m_ld, m_alu, w_ld, w_alu;
    logic         use_pc, e_cancel;
    logic [W-1:0] op_a, op_b;

    int total = 0;
    int bad = 0;
    bit done = 0;

    fwd_operand_select #(.W(W)) u_dut (
        .src_a(src_a), .src_b(src_b), .rf_a(rf_a), .rf_b(rf_b),
        .use_pc(use_pc), .pc_next(pc_next),
        .e_dst(e_dst), .e_cancel(e_cancel), .e_alu(e_alu),
        .m_dst_ld(m_dst_ld), .m_ld(m_ld), .m_dst_alu(m_dst_alu), .m_alu(m_alu),
        .w_dst_ld(w_dst_ld), .w_ld(w_ld), .w_dst_alu(w_dst_alu), .w_alu(w_alu),
        .op_a(op_a), .op_b(op_b)
    );

    // Reference: plain priority chain, youngest producer first
    function automatic logic [W-1:0] ref_pick(input logic [3:0] s, input logic [W-1:0] rf);
        if (s == 4'hF) return rf;
        if (!e_cancel && e_dst == s) return e_alu;
        if (m_dst_ld == s) return m_ld;
        if (m_dst_alu == s) return m_alu;
        if (w_dst_ld == s) return w_ld;
        if (w_dst_alu == s) return w_alu;
        return rf;
    endfunction

    function automatic string tag_for(input logic [3:0] s);
        if (s == 4'hF) return "R4";
        if (e_dst == s && e_cancel) return "R6";
        if (e_dst == s) return "R2";
        if (m_dst_ld == s || m_dst_alu == s || w_dst_ld == s || w_dst_alu == s) return "R3";
        return "R1";
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic compare_now();
        check(op_a, use_pc ? pc_next : ref_pick(src_a, rf_a), use_pc ? "R5" : tag_for(src_a));
        check(op_b, ref_pick(src_b, rf_b), {tag_for(src_b), "/R7"});
    endtask

    task automatic set_values();
        rf_a = 64'hAAAA_0000; rf_b = 64'hBBBB_0000; pc_next = 64'h1000;
        e_alu = 64'h11; m_ld = 64'h22; m_alu = 64'h33; w_ld = 64'h44; w_alu = 64'h55;
    endtask

    task automatic set_dst(input logic [3:0] e, input logic [3:0] ml, input logic [3:0] ma,
                           input logic [3:0] wl, input logic [3:0] wa);
        e_dst = e; m_dst_ld = ml; m_dst_alu = ma; w_dst_ld = wl; w_dst_alu = wa;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        set_values();
        use_pc = 0; e_cancel = 0; src_a = 4'd1; src_b = 4'd2;
        set_dst(4'hF, 4'hF, 4'hF, 4'hF, 4'hF);
        step();
        // R1: idle pipeline gives register-file values
        check(op_a, rf_a, "R1");
        check(op_b, rf_b, "R1");

        // R2: all five paths target reg 3, execute wins
        src_a = 4'd3; src_b = 4'd3; set_dst(3, 3, 3, 3, 3); step();
        check(op_a, 64'h11, "R2");
        check(op_b, 64'h11, "R2");
        // R3: priority walk
        set_dst(4'hF, 3, 3, 3, 3); step(); check(op_a, 64'h22, "R3");
        set_dst(4'hF, 4'hF, 3, 3, 3); step(); check(op_a, 64'h33, "R3");
        set_dst(4'hF, 4'hF, 4'hF, 3, 3); step(); check(op_a, 64'h44, "R3");
        set_dst(4'hF, 4'hF, 4'hF, 4'hF, 3); step(); check(op_a, 64'h55, "R3");
        // R4: source 15 with destinations 15
        src_a = 4'hF; src_b = 4'hF; set_dst(4'hF, 4'hF, 4'hF, 4'hF, 4'hF); step();
        check(op_a, rf_a, "R4");
        check(op_b, rf_b, "R4");
        // R6: cancelled execute falls to memory load
        src_a = 4'd5; src_b = 4'd5; e_cancel = 1; set_dst(5, 5, 4'hF, 4'hF, 4'hF); step();
        check(op_a, 64'h22, "R6");
        e_cancel = 0; step();
        check(op_a, 64'h11, "R6");
        // R5: PC overrides an execute match on A, B still bypassed
        use_pc = 1; step();
        check(op_a, 64'h1000, "R5");
        check(op_b, 64'h11, "R5");
        use_pc = 0;
        // R7: B follows src_b only
        src_a = 4'd5; src_b = 4'd6; set_dst(5, 4'hF, 6, 4'hF, 4'hF); step();
        check(op_a, 64'h11, "R7");
        check(op_b, 64'h33, "R7");
        src_a = 4'd6; step();
        check(op_b, 64'h33, "R7");

        // Dense collisions from a narrow ID window, model compared every clock
        for (int n = 0; n < 4000; n++) begin
            @(posedge clk);
            src_a = 4'd13 + 4'($urandom_range(0, 2));
            src_b = 4'd13 + 4'($urandom_range(0, 2));
            set_dst(4'd13 + 4'($urandom_range(0, 2)), 4'd13 + 4'($urandom_range(0, 2)),
                    4'd13 + 4'($urandom_range(0, 2)), 4'd13 + 4'($urandom_range(0, 2)),
                    4'd13 + 4'($urandom_range(0, 2)));
            use_pc = ($urandom_range(0, 3) == 0);
            e_cancel = ($urandom_range(0, 3) == 0);
            rf_a = {$urandom, $urandom}; rf_b = {$urandom, $urandom};
            pc_next = {$urandom, $urandom}; e_alu = {$urandom, $urandom};
            m_ld = {$urandom, $urandom}; m_alu = {$urandom, $urandom};
            w_ld = {$urandom, $urandom}; w_alu = {$urandom, $urandom};
            @(negedge clk);
            compare_now();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule